// File: doc/BRIEF.md
# Flash Operation Error Flag Unit

This block watches every program, erase and option-byte request that an embedded flash controller accepts. It checks each request against the control bits that are set, against the per-page write-protect map and against the read-protection level. When a check fails, it raises a sticky status flag. A separate external input lets the row-level checker set the program, size, alignment, miss and fast error flags. The unit then treats those flags the same way as its own flags.

All flags sit in one 8-bit status word. Software clears a flag by writing 1 to its bit position. The operation-error flag is raised together with the interrupt output. This happens when error interrupts are enabled and a program-class or protection error is recorded. Clear requests have no effect while a burst of back-to-back faulty writes is still running.

Top module: `flash_err_flags`

## Requirements
- R1: After reset all eight flag bits and `irq` are 0.
- R2: A data write (`wr_stb`) while both `pg_en` and `fp_en` are 0 sets the sequence flag, bit 3.
- R3: A data write while `pg_en` or `fp_en` is 1 and `pe_req` or `me_req` is also 1 sets bit 3. A write with only `pg_en` set and no earlier error sets no flag.
- R4: An erase launch (`ers_go`) sets bit 3 in two cases. The first is `me_req` together with any of `pg_en`, `fp_en` or `pe_req`. The second is `pe_req` together with any of `pg_en`, `fp_en` or `me_req`. A page erase with no conflict sets no flag.
- R5: A data write with `fp_en` set sets bit 3 if no mass erase has completed since reset. A mass erase counts as completed when it is launched without a sequence or protection error. After that, a fast-program write sets no flag.
- R6: Any attempt sets bit 3 while any of flag bits 0 to 6 is already set. An attempt is a data write, an erase launch or an option write (`opt_wr`).
- R7: The write-protect flag, bit 4, is set in three cases: a data write to a protected page, a page erase of a protected page, and a mass erase while any bit of `wp_map` is 1. A write to an unprotected page sets no flag.
- R8: With `rdp_lvl` = 1, a data write or an erase launch sets bit 4 if `dbg_attached` is 1 or `boot_main` is 0. With `rdp_lvl` = 0 these inputs cause no error.
- R9: An option write sets bit 4 when `rdp_lvl` is 2 or 3. At level 0 it sets no flag.
- R10: When `err_ie` is 1 and an error sets any of bits 0 to 5, bit 7 (operation error) is set in the same cycle, and `irq` equals bit 7. With `err_ie` 0, or when only bit 6 is set, bit 7 stays 0.
- R11: The flag layout is: bit 0 program, 1 size, 2 alignment, 3 sequence, 4 write-protect, 5 miss, 6 fast, 7 operation. Flags hold until a cycle with `clr_we` high and the matching `clr_mask` bit at 1 clears them. If a set and a clear of the same bit arrive together, the set wins.
- R12: A burst is a run of consecutive write cycles that follows an erroneous write. During a burst, and in the cycle just after it, clear requests are ignored. A clear issued after one cycle without `wr_stb` takes effect.
- R13: Each bit of `ext_err` sets one flag: `ext_err` bits 0, 1, 2, 3, 4 set flag bits 0, 1, 2, 5, 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_en | input | 1 | Standard program enable |
| fp_en | input | 1 | Fast program enable |
| pe_req | input | 1 | Page erase selected |
| me_req | input | 1 | Mass erase selected |
| wr_stb | input | 1 | Data write strobe |
| ers_go | input | 1 | Erase launch strobe |
| opt_wr | input | 1 | Option-byte modification strobe |
| tgt_page | input | PW | Target page of a write or page erase |
| wp_map | input | NPAGES | Per-page write-protect bits |
| rdp_lvl | input | 2 | Read-protection level (0, 1, 2 or 3 = level 2) |
| dbg_attached | input | 1 | Debug probe connected |
| boot_main | input | 1 | Boot source is main flash |
| ext_err | input | 5 | Set pulses from the row-level checker |
| err_ie | input | 1 | Error interrupt enable |
| clr_we | input | 1 | Write-1-to-clear strobe |
| clr_mask | input | 8 | Bits to clear |
| flags | output | 8 | Sticky status flags |
| irq | output | 1 | Error interrupt |

## Verification
The assertions assume that at most one of `wr_stb`, `ers_go` and `opt_wr` is high in any cycle. They also assume that `tgt_page` addresses an existing page. The bench drives each strobe alone for one cycle and uses page numbers below the page count. It keeps mode, protection and level inputs steady around each strobe, so each check depends on one request only.

// File: rtl/flash_err_flags.sv
module flash_err_flags #(
  parameter int NPAGES = 32,
  parameter int PW = $clog2(NPAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_en,
  input  logic              fp_en,
  input  logic              pe_req,
  input  logic              me_req,
  input  logic              wr_stb,
  input  logic              ers_go,
  input  logic              opt_wr,
  input  logic [PW-1:0]     tgt_page,
  input  logic [NPAGES-1:0] wp_map,
  input  logic [1:0]        rdp_lvl,
  input  logic              dbg_attached,
  input  logic              boot_main,
  input  logic [4:0]        ext_err,
  input  logic              err_ie,
  input  logic              clr_we,
  input  logic [7:0]        clr_mask,
  output logic [7:0]        flags,
  output logic              irq
);
  logic [7:0] flags_q;
  logic       mass_done_q;
  logic       burst_q;

  wire attempt   = wr_stb | ers_go | opt_wr;
  wire old_err   = |flags_q[6:0];
  wire any_pg    = pg_en | fp_en;
  wire rdp1_lock = (rdp_lvl == 2'd1) & (dbg_attached | ~boot_main);
  wire page_wp   = wp_map[tgt_page];

  wire seq_wr = wr_stb & (~any_pg | (any_pg & (pe_req | me_req)) | (fp_en & ~mass_done_q));
  wire seq_er = ers_go & ((me_req & (any_pg | pe_req)) | (pe_req & (any_pg | me_req)));
  wire seq_set = seq_wr | seq_er | (attempt & old_err);

  wire wp_set = (wr_stb & page_wp)
              | (ers_go & pe_req & page_wp)
              | (ers_go & me_req & (|wp_map))
              | ((wr_stb | ers_go) & rdp1_lock)
              | (opt_wr & rdp_lvl[1]);

  wire [6:0] set_vec = {ext_err[4], ext_err[3], wp_set, seq_set, ext_err[2:0]};
  wire       op_set  = err_ie & (|set_vec[5:0]);
  wire       clr_ok  = clr_we & ~burst_q;
  wire [7:0] keep    = clr_ok ? ~clr_mask : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q     <= '0;
      mass_done_q <= 1'b0;
      burst_q     <= 1'b0;
    end else begin
      flags_q <= (flags_q & keep) | {op_set, set_vec};
      burst_q <= wr_stb & (seq_set | wp_set | burst_q);
      if (ers_go & me_req & ~seq_set & ~wp_set)
        mass_done_q <= 1'b1;
    end
  end

  assign flags = flags_q;
  assign irq   = flags_q[7];
endmodule

module flash_err_flags_chk #(
  parameter int NPAGES = 32,
  parameter int PW = $clog2(NPAGES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pg_en,
  input logic              fp_en,
  input logic              pe_req,
  input logic              me_req,
  input logic              wr_stb,
  input logic              ers_go,
  input logic              opt_wr,
  input logic [PW-1:0]     tgt_page,
  input logic [NPAGES-1:0] wp_map,
  input logic [1:0]        rdp_lvl,
  input logic              err_ie,
  input logic              clr_we,
  input logic [7:0]        clr_mask,
  input logic [7:0]        flags,
  input logic              irq
);
  assert_no_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !pg_en && !fp_en |=> flags[3]);
  assert_prog_erase_mix_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && (pg_en || fp_en) && (pe_req || me_req) |=> flags[3]);
  assert_erase_mix_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ers_go && ((me_req && (pg_en || fp_en || pe_req)) || (pe_req && (pg_en || fp_en || me_req)))
    |=> flags[3]);
  assert_old_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || ers_go || opt_wr) && (|flags[6:0]) |=> flags[3]);
  assert_protected_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && wp_map[tgt_page] |=> flags[4]);
  assert_option_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    opt_wr && rdp_lvl[1] |=> flags[4]);
  assert_operr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) && $past(err_ie) |-> flags[7] && irq);
  assert_burst_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_stb) && flags[3] && clr_we && clr_mask[3] |=> flags[3]);

  for (genvar i = 0; i < 8; i++) begin : g_sticky
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flags[i]) && !$past(clr_we) |-> flags[i]);
  end
endmodule

bind flash_err_flags flash_err_flags_chk #(.NPAGES(NPAGES), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .fp_en(fp_en), .pe_req(pe_req),
  .me_req(me_req), .wr_stb(wr_stb), .ers_go(ers_go), .opt_wr(opt_wr),
  .tgt_page(tgt_page), .wp_map(wp_map), .rdp_lvl(rdp_lvl), .err_ie(err_ie),
  .clr_we(clr_we), .clr_mask(clr_mask), .flags(flags), .irq(irq)
);

// File: tb/flash_err_flags_test.sv
module flash_err_flags_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPAGES = 32;
  localparam int PW = $clog2(NPAGES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic pg_en = 0, fp_en = 0, pe_req = 0, me_req = 0;
  logic wr_stb = 0, ers_go = 0, opt_wr = 0;
  logic [PW-1:0] tgt_page = '0;
  logic [NPAGES-1:0] wp_map = '0;
  logic [1:0] rdp_lvl = 2'd0;
  logic dbg_attached = 0, boot_main = 1;
  logic [4:0] ext_err = '0;
  logic err_ie = 0, clr_we = 0;
  logic [7:0] clr_mask = '0;
  logic [7:0] flags;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_err_flags #(.NPAGES(NPAGES)) uut (
    .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .fp_en(fp_en), .pe_req(pe_req),
    .me_req(me_req), .wr_stb(wr_stb), .ers_go(ers_go), .opt_wr(opt_wr),
    .tgt_page(tgt_page), .wp_map(wp_map), .rdp_lvl(rdp_lvl),
    .dbg_attached(dbg_attached), .boot_main(boot_main), .ext_err(ext_err),
    .err_ie(err_ie), .clr_we(clr_we), .clr_mask(clr_mask), .flags(flags), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input int page);
    wr_stb = 1; tgt_page = PW'(page);
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic do_erase(input int page);
    ers_go = 1; tgt_page = PW'(page);
    @(negedge clk); ers_go = 0;
  endtask

  task automatic do_opt();
    opt_wr = 1; @(negedge clk); opt_wr = 0;
  endtask

  task automatic do_ext(input logic [4:0] m);
    ext_err = m; @(negedge clk); ext_err = '0;
  endtask

  task automatic do_clear(input logic [7:0] m);
    clr_we = 1; clr_mask = m; @(negedge clk); clr_we = 0; clr_mask = '0;
  endtask

  task automatic clear_all();
    @(negedge clk); do_clear(8'hFF);
  endtask

  task automatic t_reset();
    chk("R1 flags", flags, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_no_mode();
    do_write(1); chk("R2 no enable", flags, 8'h08);
    clear_all(); chk("R11 cleared", flags, 8'h00);
  endtask

  task automatic t_mix();
    pg_en = 1; pe_req = 1; do_write(3); chk("R3 pg+pe", flags, 8'h08);
    pe_req = 0; clear_all();
    do_write(3); chk("R3 clean program", flags, 8'h00);
    pg_en = 0;
  endtask

  task automatic t_erase_mix();
    me_req = 1; pe_req = 1; do_erase(2); chk("R4 me+pe", flags, 8'h08);
    me_req = 0; clear_all();
    fp_en = 1; do_erase(2); chk("R4 pe+fp", flags, 8'h08);
    fp_en = 0; clear_all();
    do_erase(5); chk("R4 clean page erase", flags, 8'h00);
    pe_req = 0;
  endtask

  task automatic t_fast();
    fp_en = 1; do_write(4); chk("R5 fast before mass", flags, 8'h08);
    fp_en = 0; clear_all();
    me_req = 1; do_erase(0); chk("R5 mass erase", flags, 8'h00);
    me_req = 0; fp_en = 1; do_write(4); chk("R5 fast after mass", flags, 8'h00);
    fp_en = 0;
  endtask

  task automatic t_old();
    do_ext(5'b00001); chk("R6 prior prog", flags, 8'h01);
    pg_en = 1; do_write(2); chk("R6 write on old error", flags, 8'h09);
    pg_en = 0; clear_all();
  endtask

  task automatic t_wp();
    wp_map[7] = 1'b1; pg_en = 1;
    do_write(7); chk("R7 protected write", flags, 8'h10);
    clear_all(); do_write(6); chk("R7 open write", flags, 8'h00);
    pg_en = 0; pe_req = 1; do_erase(7); chk("R7 protected page erase", flags, 8'h10);
    pe_req = 0; clear_all();
    me_req = 1; do_erase(0); chk("R7 mass with protection", flags, 8'h10);
    me_req = 0; clear_all(); wp_map = '0;
  endtask

  task automatic t_rdp1();
    pg_en = 1; rdp_lvl = 2'd1; dbg_attached = 1;
    do_write(2); chk("R8 level1 debug", flags, 8'h10);
    clear_all(); dbg_attached = 0; boot_main = 0; pg_en = 0; pe_req = 1;
    do_erase(2); chk("R8 level1 boot", flags, 8'h10);
    clear_all(); boot_main = 1; pe_req = 0; pg_en = 1;
    do_write(2); chk("R8 level1 clean", flags, 8'h00);
    rdp_lvl = 2'd0; dbg_attached = 1;
    do_write(2); chk("R8 level0 debug", flags, 8'h00);
    dbg_attached = 0; pg_en = 0;
  endtask

  task automatic t_opt();
    rdp_lvl = 2'd2; do_opt(); chk("R9 level2 option", flags, 8'h10);
    clear_all(); rdp_lvl = 2'd0; do_opt(); chk("R9 level0 option", flags, 8'h00);
  endtask

  task automatic t_irq();
    err_ie = 1; do_write(1);
    chk("R10 operr", flags, 8'h88); chk("R10 irq", {7'd0, irq}, 8'h01);
    clear_all(); chk("R10 irq cleared", {7'd0, irq}, 8'h00);
    do_ext(5'b10000); chk("R10 fast only", flags, 8'h40);
    clear_all(); err_ie = 0;
    do_write(1); chk("R10 disabled", flags, 8'h08);
    chk("R10 no irq", {7'd0, irq}, 8'h00);
    clear_all();
  endtask

  task automatic t_w1c();
    do_ext(5'b00111); chk("R11 three set", flags, 8'h07);
    do_clear(8'h02); chk("R11 partial clear", flags, 8'h05);
    repeat (3) @(negedge clk); chk("R11 sticky", flags, 8'h05);
    clear_all(); chk("R11 full clear", flags, 8'h00);
  endtask

  task automatic t_burst();
    do_write(1);
    do_clear(8'h08); chk("R12 clear in burst ignored", flags, 8'h08);
    do_clear(8'h08); chk("R12 clear after idle", flags, 8'h00);
    wr_stb = 1; @(negedge clk);
    clr_we = 1; clr_mask = 8'h08; @(negedge clk);
    wr_stb = 0; clr_we = 0; clr_mask = '0;
    chk("R12 clear during writes", flags, 8'h08);
    clear_all();
  endtask

  task automatic t_ext();
    do_ext(5'b01000); chk("R13 miss", flags, 8'h20);
    clear_all(); do_ext(5'b10000); chk("R13 fast", flags, 8'h40);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_no_mode(); t_mix(); t_erase_mix(); t_fast(); t_old();
    t_wp(); t_rdp1(); t_opt(); t_irq(); t_w1c(); t_burst(); t_ext();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule